// File: doc/BRIEF.md
# Infrared Carrier Modulator with Frequency-Shift Keying

This block drives one infrared output pin. Software programs it through a byte-wide register port. A two-stage clock divider produces a modulator tick. A carrier generator toggles between a high count and a low count of ticks. A mark/space envelope counter then gates that carrier, or replaces it, to build one modulation cycle after another.

Four behaviours come from three control bits. In direct control, a software level bit drives the pin. In time mode, the carrier is gated by the envelope. In baseband mode, the envelope alone drives the pin. In frequency-shift mode, two carrier count pairs take turns on alternating cycles. At the end of every cycle the block sets a flag, which can raise an interrupt line. A polarity bit and an output-enable bit shape the final pin level.

Register map (4-bit address): 0 prescaler; 1 control; 2 output control; 3 carrier set-1 high count; 4 carrier set-1 low count; 5 carrier set-2 high count; 6 carrier set-2 low count; 7 mark upper byte; 8 mark lower byte; 9 space upper byte; 10 space lower byte.

Control register bits:
- bit 0: run.
- bit 1: baseband.
- bit 2: frequency shift.
- bit 3: interrupt enable.
- bits 6:4: secondary divide code.
- bit 7: end-of-cycle flag. It is read-only; a write to this bit is ignored.

Output control register bits:
- bit 0: software level.
- bit 1: polarity (1 = active-low).
- bit 2: output enable.

Top module: `irm_top`

## Requirements
- R1: After reset, the output control register reads 0x04 (output enabled, active-high, level 0). The control register reads 0x00. `ir_out` is 0 and `irq` is 0.
- R2: One modulator tick lasts (prescaler + 1) × F clocks. F comes from control bits 6:4: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 1.
- R3: The mode is decoded with a fixed priority. Control bit 0 clear selects direct control. Otherwise bit 1 set selects baseband, even when bit 2 is also set. Otherwise bit 2 set selects frequency shift. Otherwise the mode is time mode.
- R4: In direct control, `ir_out` follows output control bit 0, after polarity is applied.
- R5: In time mode, each cycle has a mark of (mark + 1) ticks followed by a space of (space + 1) ticks at the inactive level. During the mark the carrier is high for H ticks and low for L ticks, repeating. The carrier restarts high at the start of every mark. A count of 0 is treated as 1.
- R6: In baseband mode, the pin is at the active level for (mark + 1) ticks and at the inactive level for (space + 1) ticks.
- R7: In frequency-shift mode, the first cycle after start uses carrier set 1 (addresses 3 and 4). The next cycle uses set 2 (addresses 5 and 6), and the two sets keep alternating at each end of cycle.
- R8: Mark and space are 16-bit values, each written as an upper byte and a lower byte. A value written during a cycle takes effect only from the following cycle.
- R9: Control bit 7 is set at the end of every cycle. `irq` equals this flag ANDed with control bit 3. Any read or write of the control register clears the flag; if the flag is set in the same cycle, the set wins.
- R10: Output control bit 1 inverts the pin. When output control bit 2 is clear, the pin is held at its inactive level (0 when active-high, 1 when active-low).
- R11: Writing 0 to the control register stops modulation, and the pin returns to the software level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used to clear the flag) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ir_out | output | 1 | Infrared output pin |
| irq | output | 1 | End-of-cycle interrupt request |

## Verification
The bench builds the block with its default widths: an 8-bit prescaler, 8-bit carrier counts and 16-bit mark/space counts.

Prescaler values of 0 to 2 keep ticks at one to eight clocks, so each waveform fits in a few hundred clocks. Every divide code can be reached, including an unlisted code.

A mark value above 255 exercises the upper byte without making the run long. Small carrier counts let the frequency-shift alternation show within two cycles.

// File: rtl/irm_pkg.sv
package irm_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_TIME   = 2'd1,
    MODE_BASE   = 2'd2,
    MODE_FSK    = 2'd3
  } irm_mode_e;

  localparam logic [3:0] A_PRESC = 4'd0;
  localparam logic [3:0] A_CTRL  = 4'd1;
  localparam logic [3:0] A_OUTC  = 4'd2;
  localparam logic [3:0] A_C1H   = 4'd3;
  localparam logic [3:0] A_C1L   = 4'd4;
  localparam logic [3:0] A_C2H   = 4'd5;
  localparam logic [3:0] A_C2L   = 4'd6;
  localparam logic [3:0] A_MKH   = 4'd7;
  localparam logic [3:0] A_MKL   = 4'd8;
  localparam logic [3:0] A_SPH   = 4'd9;
  localparam logic [3:0] A_SPL   = 4'd10;

  // Priority: run clear -> direct; baseband beats frequency shift.
  function automatic irm_mode_e decode_mode(input logic run, input logic base,
                                            input logic fsk);
    if (!run)      return MODE_DIRECT;
    else if (base) return MODE_BASE;
    else if (fsk)  return MODE_FSK;
    else           return MODE_TIME;
  endfunction

  // Secondary divide factor; unlisted codes divide by one.
  function automatic logic [3:0] sdiv_factor(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/irm_clkdiv.sv
module irm_clkdiv #(
  parameter int PRE_W = 8,
  parameter int SD_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] presc,
  input  logic [SD_W-1:0]  sdiv,
  output logic             tick
);
  import irm_pkg::*;

  logic [PRE_W-1:0] pcnt;
  logic [3:0]       scnt;
  logic [3:0]       factor;
  logic             imd;

  assign factor = sdiv_factor(sdiv[2:0]);
  assign imd    = en && (pcnt == presc);
  assign tick   = imd && (scnt == factor - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (!en) begin
      pcnt <= '0;
      scnt <= '0;
    end else begin
      pcnt <= imd ? '0 : pcnt + 1'b1;
      if (imd) scnt <= tick ? 4'd0 : scnt + 4'd1;
    end
  end
endmodule

// File: rtl/irm_carrier.sv
module irm_carrier #(
  parameter int HL_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            tick,
  input  logic [HL_W-1:0] hi_cnt,
  input  logic [HL_W-1:0] lo_cnt,
  output logic            carrier
);
  logic            phase_hi;
  logic [HL_W-1:0] cnt;
  logic [HL_W:0]   cur_len;
  logic            last;

  function automatic logic [HL_W:0] at_least_one(input logic [HL_W-1:0] v);
    return (v == '0) ? {{HL_W{1'b0}}, 1'b1} : {1'b0, v};
  endfunction

  assign cur_len = phase_hi ? at_least_one(hi_cnt) : at_least_one(lo_cnt);
  assign last    = ({1'b0, cnt} + 1'b1) >= cur_len;
  assign carrier = phase_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
    end else if (hold) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
    end else if (tick) begin
      if (last) begin
        phase_hi <= ~phase_hi;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irm_envelope.sv
module irm_envelope #(
  parameter int MS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [MS_W-1:0] mark_in,
  input  logic [MS_W-1:0] space_in,
  output logic            active,
  output logic            in_mark,
  output logic            eoc
);
  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} env_st_e;

  env_st_e         st;
  logic [MS_W-1:0] mark_q, space_q, cnt;

  assign active  = (st != ST_IDLE);
  assign in_mark = (st == ST_MARK);
  assign eoc     = (st == ST_SPACE) && tick && (cnt == space_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      mark_q  <= '0;
      space_q <= '0;
    end else if (!run) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          st      <= ST_MARK;
          cnt     <= '0;
          mark_q  <= mark_in;
          space_q <= space_in;
        end
        ST_MARK: if (tick) begin
          if (cnt == mark_q) begin
            st  <= ST_SPACE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: if (tick) begin
          if (eoc) begin
            st      <= ST_MARK;
            cnt     <= '0;
            mark_q  <= mark_in;
            space_q <= space_in;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/irm_top.sv
module irm_top #(
  parameter int PRE_W = 8,
  parameter int HL_W  = 8,
  parameter int MS_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ir_out,
  output logic       irq
);
  import irm_pkg::*;

  localparam int MS_BYTES = MS_W / 8;
  localparam int SD_W     = 3;

  logic [PRE_W-1:0] presc_q;
  logic             run_q, base_q, fsk_q, ie_q, flag_q;
  logic [SD_W-1:0]  sdiv_q;
  logic             lvl_q, pol_q, oen_q;
  logic [HL_W-1:0]  c1h_q, c1l_q, c2h_q, c2l_q;
  logic [15:0]      mark_q, space_q;
  logic             fsk_sel_q;
  logic             ir_q;

  // Named internal events used by the checker.
  irm_mode_e        mode_w;
  logic             tick_w, eoc_w, env_active_w, in_mark_w, carrier_w;
  logic             ctrl_touch_w;
  logic [HL_W-1:0]  hi_sel_w, lo_sel_w;
  logic             mod_lvl_w;

  assign mode_w       = decode_mode(run_q, base_q, fsk_q);
  assign ctrl_touch_w = (wr_en || rd_en) && (addr == A_CTRL);
  assign hi_sel_w     = fsk_sel_q ? c2h_q : c1h_q;
  assign lo_sel_w     = fsk_sel_q ? c2l_q : c1l_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      run_q <= 1'b0; base_q <= 1'b0; fsk_q <= 1'b0; ie_q <= 1'b0;
      sdiv_q <= '0;
      lvl_q <= 1'b0; pol_q <= 1'b0; oen_q <= 1'b1;
      c1h_q <= '0; c1l_q <= '0; c2h_q <= '0; c2l_q <= '0;
      mark_q <= '0; space_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PRESC: presc_q <= wdata[PRE_W-1:0];
        A_CTRL: begin
          run_q  <= wdata[0];
          base_q <= wdata[1];
          fsk_q  <= wdata[2];
          ie_q   <= wdata[3];
          sdiv_q <= wdata[6:4];
        end
        A_OUTC: begin
          lvl_q <= wdata[0];
          pol_q <= wdata[1];
          oen_q <= wdata[2];
        end
        A_C1H: c1h_q <= wdata[HL_W-1:0];
        A_C1L: c1l_q <= wdata[HL_W-1:0];
        A_C2H: c2h_q <= wdata[HL_W-1:0];
        A_C2L: c2l_q <= wdata[HL_W-1:0];
        A_MKH: mark_q[15:8]  <= wdata;
        A_MKL: mark_q[7:0]   <= wdata;
        A_SPH: space_q[15:8] <= wdata;
        A_SPL: space_q[7:0]  <= wdata;
        default: ;
      endcase
    end
  end

  // Flag: set by end of cycle (wins), cleared by any control access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (eoc_w)        flag_q <= 1'b1;
    else if (ctrl_touch_w) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           fsk_sel_q <= 1'b0;
    else if (!env_active_w)               fsk_sel_q <= 1'b0;
    else if (eoc_w && mode_w == MODE_FSK) fsk_sel_q <= ~fsk_sel_q;
  end

  irm_clkdiv #(.PRE_W(PRE_W), .SD_W(SD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(env_active_w),
    .presc(presc_q), .sdiv(sdiv_q), .tick(tick_w)
  );

  irm_envelope #(.MS_W(MS_W)) u_env (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_w),
    .mark_in(mark_q[MS_W-1:0]), .space_in(space_q[MS_W-1:0]),
    .active(env_active_w), .in_mark(in_mark_w), .eoc(eoc_w)
  );

  irm_carrier #(.HL_W(HL_W)) u_car (
    .clk(clk), .rst_n(rst_n), .hold(!in_mark_w), .tick(tick_w),
    .hi_cnt(hi_sel_w), .lo_cnt(lo_sel_w), .carrier(carrier_w)
  );

  always_comb begin
    case (mode_w)
      MODE_DIRECT: mod_lvl_w = lvl_q;
      MODE_BASE:   mod_lvl_w = in_mark_w;
      default:     mod_lvl_w = in_mark_w & carrier_w;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= 1'b0;
    else        ir_q <= (oen_q & mod_lvl_w) ^ pol_q;
  end

  always_comb begin
    case (addr)
      A_PRESC: rdata = 8'(presc_q);
      A_CTRL:  rdata = {flag_q, sdiv_q, ie_q, fsk_q, base_q, run_q};
      A_OUTC:  rdata = {5'd0, oen_q, pol_q, lvl_q};
      A_C1H:   rdata = 8'(c1h_q);
      A_C1L:   rdata = 8'(c1l_q);
      A_C2H:   rdata = 8'(c2h_q);
      A_C2L:   rdata = 8'(c2l_q);
      A_MKH:   rdata = mark_q[15:8];
      A_MKL:   rdata = mark_q[7:0];
      A_SPH:   rdata = space_q[15:8];
      A_SPL:   rdata = space_q[7:0];
      default: rdata = 8'd0;
    endcase
  end

  assign ir_out = ir_q;
  assign irq    = flag_q & ie_q;

  if (MS_BYTES < 1) begin : g_bad_width
    initial $display("irm_top: MS_W must be at least 8");
  end
endmodule

// File: rtl/irm_checker.sv
module irm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       tick,
  input logic       eoc,
  input logic       env_active,
  input logic       in_mark,
  input logic       fsk_sel,
  input logic       ie,
  input logic       irq,
  input logic       out_en,
  input logic       pol,
  input logic       level,
  input logic       ir_out
);
  import irm_pkg::*;

  p_eoc_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (env_active && tick));

  p_irq_after_eoc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && ie) |=> irq);

  p_direct_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DIRECT && out_en) |=> (ir_out == ($past(level) ^ $past(pol))));

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (ir_out == $past(pol)));

  p_base_envelope_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BASE && out_en) |=> (ir_out == ($past(in_mark) ^ $past(pol))));

  p_space_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TIME && !in_mark) |=> (ir_out == $past(pol)));

  p_fsk_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && mode == MODE_FSK) |=> (fsk_sel != $past(fsk_sel)));
endmodule

bind irm_top irm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_w), .tick(tick_w), .eoc(eoc_w),
  .env_active(env_active_w), .in_mark(in_mark_w), .fsk_sel(fsk_sel_q),
  .ie(ie_q), .irq(irq), .out_en(oen_q), .pol(pol_q), .level(lvl_q),
  .ir_out(ir_out)
);

// File: tb/irm_top_tb_top.sv
module irm_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ir_out, irq;

  int checks = 0;
  int errors = 0;

  // Scoreboard queues of expected runs (level, length in clocks).
  bit exp_lvl_q[$];
  int exp_len_q[$];
  bit arm = 1'b0;
  bit done = 1'b0;
  bit act_lvl = 1'b1;
  string cur_tag = "";

  always #2 clk = ~clk;

  irm_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ir_out(ir_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Driver: tick-level model of the requirements, run-length coded.
  task automatic push_wave(input bit base, input bit fsk, input int h1, input int l1,
                           input int h2, input int l2, input int mk0, input int mk1,
                           input int sp, input int ncyc, input int per, input bit act);
    bit ticks[$];
    bit cur;
    int n;
    for (int c = 0; c < ncyc; c++) begin
      int mk = (c == 0) ? mk0 : mk1;
      int h = (fsk && (c % 2 == 1)) ? h2 : h1;
      int l = (fsk && (c % 2 == 1)) ? l2 : l1;
      if (h < 1) h = 1;
      if (l < 1) l = 1;
      for (int j = 0; j <= mk; j++) ticks.push_back(base ? 1'b1 : ((j % (h + l)) < h));
      for (int j = 0; j <= sp; j++) ticks.push_back(1'b0);
    end
    cur = ticks[0];
    n = 0;
    foreach (ticks[i]) begin
      if (ticks[i] == cur) n++;
      else begin
        exp_lvl_q.push_back(act ? cur : !cur);
        exp_len_q.push_back(n * per);
        cur = ticks[i];
        n = 1;
      end
    end
    // The last run may merge with the next cycle, so it is not pushed.
  endtask

  // Monitor: waits for the first active edge, then measures and pops runs.
  initial begin
    bit lvl;
    int n;
    bit el;
    int en;
    forever begin
      wait (arm);
      @(negedge clk);
      while (ir_out !== act_lvl) @(negedge clk);
      while (exp_len_q.size() > 0) begin
        lvl = ir_out;
        n = 0;
        while (ir_out === lvl) begin
          n++;
          @(negedge clk);
        end
        el = exp_lvl_q.pop_front();
        en = exp_len_q.pop_front();
        chk(lvl == el && n == en, cur_tag, "run level*1000+length",
            int'(lvl) * 1000 + n, int'(el) * 1000 + en);
      end
      done = 1'b1;
      arm = 1'b0;
    end
  end

  task automatic run_and_wait(input logic [7:0] ctrl, input string tag);
    cur_tag = tag;
    done = 1'b0;
    arm = 1'b1;
    wr(4'd1, ctrl);
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(done, tag, "scoreboard finished", int'(done), 1);
    arm = 1'b0;
    wr(4'd1, 8'h00);
    repeat (4) @(negedge clk);
    exp_lvl_q.delete();
    exp_len_q.delete();
  endtask

  task automatic set_pair(input int mk, input int sp);
    wr(4'd7, 8'(mk >> 8)); wr(4'd8, 8'(mk));
    wr(4'd9, 8'(sp >> 8)); wr(4'd10, 8'(sp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd2, d); chk(d == 8'h04, "R1", "output control", d, 8'h04);
    rd(4'd1, d); chk(d == 8'h00, "R1", "control", d, 0);
    chk(ir_out == 1'b0, "R1", "ir_out", ir_out, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);

    // R4 direct control follows the level bit
    wr(4'd2, 8'h05); repeat (2) @(negedge clk);
    chk(ir_out == 1'b1, "R4", "direct level 1", ir_out, 1);
    wr(4'd2, 8'h04); repeat (2) @(negedge clk);
    chk(ir_out == 1'b0, "R4", "direct level 0", ir_out, 0);

    // R5 + R2: time mode, prescaler 0, divide code 0
    wr(4'd0, 8'd0); wr(4'd3, 8'd2); wr(4'd4, 8'd3);
    set_pair(9, 4);
    push_wave(0, 0, 2, 3, 0, 0, 9, 9, 4, 3, 1, 1);
    run_and_wait(8'h01, "R5");
    wait_done("R5");

    // R6 + R2: baseband, prescaler 1, divide code 2 -> 8 clocks per tick
    wr(4'd0, 8'd1); set_pair(3, 2);
    push_wave(1, 0, 1, 1, 1, 1, 3, 3, 2, 3, 8, 1);
    run_and_wait(8'h23, "R6");
    wait_done("R6");

    // R2: unlisted divide code 5 behaves as divide by one (prescaler 2 -> 3)
    wr(4'd0, 8'd2); set_pair(4, 6);
    push_wave(1, 0, 1, 1, 1, 1, 4, 4, 6, 3, 3, 1);
    run_and_wait(8'h53, "R2");
    wait_done("R2");

    // R3: baseband wins over frequency shift when both are set
    wr(4'd0, 8'd0); wr(4'd3, 8'd1); wr(4'd4, 8'd1); set_pair(5, 3);
    push_wave(1, 0, 1, 1, 1, 1, 5, 5, 3, 3, 1, 1);
    run_and_wait(8'h07, "R3");
    wait_done("R3");

    // R7: frequency shift, sets alternate, divide by 2
    wr(4'd3, 8'd1); wr(4'd4, 8'd1); wr(4'd5, 8'd3); wr(4'd6, 8'd2);
    set_pair(7, 3);
    push_wave(0, 1, 1, 1, 3, 2, 7, 7, 3, 4, 2, 1);
    run_and_wait(8'h15, "R7");
    wait_done("R7");

    // R8: 16-bit mark written mid-cycle applies from the next cycle
    wr(4'd0, 8'd1); set_pair(5, 2);
    push_wave(1, 0, 1, 1, 1, 1, 5, 258, 2, 3, 2, 1);
    run_and_wait(8'h03, "R8");
    wr(4'd7, 8'h01); wr(4'd8, 8'h02);
    wait_done("R8");

    // R10: active-low polarity inverts the time-mode waveform
    wr(4'd0, 8'd0); wr(4'd3, 8'd2); wr(4'd4, 8'd3); set_pair(9, 4);
    wr(4'd2, 8'h06);
    act_lvl = 1'b0;
    push_wave(0, 0, 2, 3, 0, 0, 9, 9, 4, 2, 1, 0);
    run_and_wait(8'h01, "R10");
    wait_done("R10");
    act_lvl = 1'b1;

    // R10: output disabled holds the inactive level for either polarity
    wr(4'd2, 8'h00); wr(4'd1, 8'h01);
    seen = 1'b0;
    repeat (80) begin @(negedge clk); if (ir_out) seen = 1'b1; end
    chk(!seen, "R10", "disabled active-high stays 0", seen, 0);
    wr(4'd2, 8'h02);
    seen = 1'b0;
    repeat (80) begin @(negedge clk); if (!ir_out) seen = 1'b1; end
    chk(!seen, "R10", "disabled active-low stays 1", !seen, 1);
    wr(4'd1, 8'h00);

    // R9: no irq while interrupt enable is clear, flag still set
    wr(4'd2, 8'h04); set_pair(9, 9);
    wr(4'd1, 8'h01);
    seen = 1'b0;
    repeat (60) begin @(negedge clk); if (irq) seen = 1'b1; end
    chk(!seen, "R9", "irq masked", seen, 0);
    rd(4'd1, d); chk(d[7] == 1'b1, "R9", "flag set while masked", d[7], 1);
    wr(4'd1, 8'h00);

    // R9: irq rises with enable, a read clears it
    wr(4'd1, 8'h09);
    seen = 1'b0;
    for (int k = 0; k < 100 && !seen; k++) begin @(negedge clk); if (irq) seen = 1'b1; end
    chk(seen, "R9", "irq raised", seen, 1);
    rd(4'd1, d); chk(d[7] == 1'b1, "R9", "flag read", d[7], 1);
    chk(irq == 1'b0, "R9", "irq cleared by read", irq, 0);

    // R11: writing zero stops modulation, pin returns to the level bit
    wr(4'd2, 8'h05);
    wr(4'd1, 8'h00);
    repeat (2) @(negedge clk);
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (!ir_out) seen = 1'b1; end
    chk(!seen, "R11", "stopped output holds level 1", !seen, 1);
    rd(4'd1, d); chk(d == 8'h00, "R11", "control reads zero", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule